// File: doc/BRIEF.md
# Programmable Format Asynchronous Transmitter

This block turns an 8-bit parallel word into one asynchronous serial character on a single output line. A five-bit format code picks the number of data bits (5 to 8), whether a parity bit is added, its sense (even or odd), and the stop length. The block adds the start bit, the parity bit and the stop bits itself. The line rests high.

The clock runs at sixteen times the bit rate, so one bit occupies sixteen clocks. A one-word holding buffer sits in front of the shift register. Software can write the next word while the current character is still going out, and the next character then follows with no idle gap. Two flags report progress: one says the holding buffer can take a word, the other says the whole transmitter has gone quiet.

The format code is captured when each character starts. Changing it while a character is on the line therefore has no effect on that character.

Top module: `fmt_async_tx`

## Requirements
- R1: While reset is active and right after it, `txd` is 1, `hold_empty` is 1 and `tx_empty` is 1.
- R2: A character begins with a start bit of 0, and its data bits follow least significant bit first. Every start, data and parity bit holds `txd` steady for exactly 16 clocks.
- R3: `fmt_len` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above that length are not sent.
- R4: With `fmt_par_off`=1 there is no parity bit. With `fmt_par_off`=0, a parity bit follows the last data bit. If `fmt_par_even`=1, the data bits plus this bit hold an even number of ones. If `fmt_par_even`=0, they hold an odd number.
- R5: Stop bits drive `txd` high. With `fmt_stop_sel`=0 the stop lasts 16 clocks. With `fmt_stop_sel`=1 it lasts 24 clocks for 5-bit words and 32 clocks for 6, 7 or 8-bit words.
- R6: `hold_empty` goes low the cycle after a `wr_stb` pulse. It goes high again the cycle after the buffered word moves into the shift register.
- R7: A word written while a character is being sent moves into the shift register on the last stop clock. Its start bit follows that stop clock with no idle cycle in between.
- R8: `tx_empty` is 1 only when the holding buffer is empty, no character is being sent and `txd` is high.
- R9: The format inputs are sampled when a character starts. Changing them during a character leaves that character unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_len | input | 2 | Data length code (00=5 to 11=8 bits) |
| fmt_par_off | input | 1 | 1 = no parity bit |
| fmt_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| fmt_stop_sel | input | 1 | 0 = one stop bit, 1 = longer stop |
| wr_stb | input | 1 | One-cycle strobe that writes `wr_data` into the holding buffer |
| wr_data | input | 8 | Word to transmit |
| txd | output | 1 | Serial line output, high when idle |
| hold_empty | output | 1 | Holding buffer can accept a word |
| tx_empty | output | 1 | Buffer and shift register empty, line idle |

## Verification
The assertions check, on every cycle, the properties that hold locally:
- The line is high in idle and during stop.
- A bit does not change inside its 16-clock window.
- A start bit follows each load.
- A load happens only when the shifter is ready.
- The buffer flag responds to strobes and transfers.
- The captured stop length stays fixed for the whole character.

The values actually sent need the bench's scenarios. These include the data bits for each length, the parity sense, the exact stop length, back-to-back characters without a gap, and format changes made in the middle of a character. The bench predicts each of these bit by bit at the line.

// File: rtl/fmtx_pkg.sv
package fmtx_pkg;

  localparam int unsigned FMTX_DATA_W  = 8;
  localparam int unsigned FMTX_FRAME_W = FMTX_DATA_W + 2;

  typedef struct packed {
    logic [1:0] len;
    logic       par_off;
    logic       par_even;
    logic       stop_sel;
  } fmtx_ctrl_t;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_BITS = 2'd1,
    SH_STOP = 2'd2
  } fmtx_state_e;

  // number of data bits for a length code
  function automatic logic [3:0] word_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // parity bit over the enabled data bits
  function automatic logic par_bit(input logic [FMTX_DATA_W-1:0] d,
                                   input logic [1:0] len,
                                   input logic even);
    logic [FMTX_DATA_W-1:0] mask;
    mask = {FMTX_DATA_W{1'b1}} >> (2'd3 - len);
    return even ? (^(d & mask)) : ~(^(d & mask));
  endfunction

endpackage

// File: rtl/fmtx_hold.sv
module fmtx_hold
  import fmtx_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [FMTX_DATA_W-1:0] wr_data,
  input  logic                   take,
  output logic [FMTX_DATA_W-1:0] hold_data,
  output logic                   hold_full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else begin
      if (wr_stb) begin
        hold_data <= wr_data;
        hold_full <= 1'b1;
      end else if (take) begin
        hold_full <= 1'b0;
      end
    end
  end

  AST_STB_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> hold_full); // R6
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    take && !wr_stb |=> !hold_full); // R6
  AST_TAKE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> hold_full); // R7

endmodule

// File: rtl/fmtx_frame.sv
module fmtx_frame
  import fmtx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  localparam int unsigned CW = $clog2(2 * OVS)
) (
  input  fmtx_ctrl_t              ctrl,
  input  logic [FMTX_DATA_W-1:0]  data,
  output logic [FMTX_FRAME_W-1:0] frame,
  output logic [3:0]              nbits,
  output logic [CW-1:0]           stop_last
);

  localparam logic [CW-1:0] ONE_LAST  = CW'(OVS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OVS + OVS / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OVS - 1);

  logic [3:0] n_data;
  logic       p_val;
  logic [FMTX_DATA_W-1:0] slot;

  assign n_data = word_bits(ctrl.len);
  assign p_val  = par_bit(data, ctrl.len, ctrl.par_even);

  // data bits beyond the word length become idle-level ones
  for (genvar i = 0; i < FMTX_DATA_W; i++) begin : g_slot
    assign slot[i] = (4'(i) < n_data) ? data[i] : 1'b1;
  end

  always_comb begin
    frame = {1'b1, slot, 1'b0};
    if (!ctrl.par_off) frame[n_data + 4'd1] = p_val;
  end

  assign nbits = 4'd1 + n_data + {3'b000, ~ctrl.par_off};

  always_comb begin
    if (!ctrl.stop_sel)           stop_last = ONE_LAST;
    else if (ctrl.len == 2'b00)   stop_last = HALF_LAST;
    else                          stop_last = TWO_LAST;
  end

endmodule

// File: rtl/fmtx_shift.sv
module fmtx_shift
  import fmtx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  localparam int unsigned CW = $clog2(2 * OVS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [FMTX_FRAME_W-1:0] frame,
  input  logic [3:0]              nbits,
  input  logic [CW-1:0]           stop_last,
  output logic                    txd,
  output logic                    ready,
  output logic                    idle
);

  localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

  fmtx_state_e             state;
  logic [FMTX_FRAME_W-1:0] sh;
  logic [3:0]              left;
  logic [CW-1:0]           cnt;
  logic [CW-1:0]           stop_end;
  logic                    bit_done;
  logic                    stop_done;

  assign bit_done  = (state == SH_BITS) && (cnt == BIT_LAST);
  assign stop_done = (state == SH_STOP) && (cnt == stop_end);
  assign ready     = (state == SH_IDLE) || stop_done;
  assign idle      = (state == SH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      txd      <= 1'b1;
      sh       <= '1;
      left     <= '0;
      cnt      <= '0;
      stop_end <= '0;
    end else if (load) begin
      txd      <= frame[0];
      sh       <= frame >> 1;
      left     <= nbits - 4'd1;
      cnt      <= '0;
      stop_end <= stop_last;
      state    <= SH_BITS;
    end else begin
      unique case (state)
        SH_BITS: begin
          if (bit_done) begin
            cnt <= '0;
            if (left == 4'd0) begin
              state <= SH_STOP;
              txd   <= 1'b1;
            end else begin
              txd  <= sh[0];
              sh   <= sh >> 1;
              left <= left - 4'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SH_STOP: begin
          if (stop_done) begin
            state <= SH_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: txd <= 1'b1;
      endcase
    end
  end

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    state == SH_IDLE |-> txd); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd && state == SH_BITS); // R2
  AST_BIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    state == SH_BITS && cnt != '0 |-> $stable(txd)); // R2
  AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    state == SH_STOP |-> txd); // R5
  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == SH_STOP |-> cnt <= stop_end); // R5
  AST_LOAD_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ready); // R7
  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    state != SH_IDLE && !load |=> $stable(stop_end)); // R9

endmodule

// File: rtl/fmt_async_tx.sv
module fmt_async_tx
  import fmtx_pkg::*;
#(
  parameter int unsigned OVS = 16,
  localparam int unsigned CW = $clog2(2 * OVS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fmt_len,
  input  logic       fmt_par_off,
  input  logic       fmt_par_even,
  input  logic       fmt_stop_sel,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty
);

  fmtx_ctrl_t              ctrl;
  logic [FMTX_DATA_W-1:0]  hold_data;
  logic                    hold_full;
  logic                    take;
  logic                    sh_ready;
  logic                    sh_idle;
  logic [FMTX_FRAME_W-1:0] frame;
  logic [3:0]              nbits;
  logic [CW-1:0]           stop_last;

  assign ctrl = '{len: fmt_len, par_off: fmt_par_off,
                  par_even: fmt_par_even, stop_sel: fmt_stop_sel};
  assign take = hold_full && sh_ready;

  fmtx_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .take      (take),
    .hold_data (hold_data),
    .hold_full (hold_full)
  );

  fmtx_frame #(.OVS(OVS)) u_frame (
    .ctrl      (ctrl),
    .data      (hold_data),
    .frame     (frame),
    .nbits     (nbits),
    .stop_last (stop_last)
  );

  fmtx_shift #(.OVS(OVS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take),
    .frame     (frame),
    .nbits     (nbits),
    .stop_last (stop_last),
    .txd       (txd),
    .ready     (sh_ready),
    .idle      (sh_idle)
  );

  assign hold_empty = !hold_full;
  assign tx_empty   = hold_empty && sh_idle;

  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd); // R8
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && sh_ready |=> !txd); // R7

endmodule

// File: tb/fmt_async_tx_bench.sv
module fmt_async_tx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {ctrl = len[1:0],par_off,par_even,stop_sel ; data ; data bits ; stop clocks}
  localparam logic [22:0] VEC [NVEC] = '{
    {5'b00010, 8'h15, 4'd5, 6'd16},
    {5'b00001, 8'h0A, 4'd5, 6'd24},
    {5'b01100, 8'h2C, 4'd6, 6'd16},
    {5'b01011, 8'hFF, 4'd6, 6'd32},
    {5'b10000, 8'h55, 4'd7, 6'd16},
    {5'b10111, 8'h80, 4'd7, 6'd32},
    {5'b11010, 8'hA5, 4'd8, 6'd16},
    {5'b11001, 8'h00, 4'd8, 6'd32},
    {5'b00101, 8'h1F, 4'd5, 6'd24}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] fmt_len = 2'b00;
  logic fmt_par_off = 1'b0, fmt_par_even = 1'b0, fmt_stop_sel = 1'b0;
  logic wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, hold_empty, tx_empty;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fmt_async_tx u_fmt_async_tx (
    .clk(clk), .rst_n(rst_n), .fmt_len(fmt_len), .fmt_par_off(fmt_par_off),
    .fmt_par_even(fmt_par_even), .fmt_stop_sel(fmt_stop_sel), .wr_stb(wr_stb),
    .wr_data(wr_data), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected line level at clock k of a character
  function automatic bit exp_line(input logic [4:0] c, input logic [7:0] d, input int k);
    int n, idx, ones;
    n = 5 + int'(c[4:3]);
    idx = k / 16;
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(d[i]);
    if (idx == 0) return 1'b0;
    if (idx <= n) return d[idx-1];
    if (!c[2] && idx == n + 1) return c[1] ? bit'(ones % 2) : bit'(1 - ones % 2);
    return 1'b1;
  endfunction

  function automatic int frame_len(input logic [4:0] c, input int bits, input int stop);
    return 16 * (1 + bits + (c[2] ? 0 : 1)) + stop;
  endfunction

  task automatic set_ctrl(input logic [4:0] c);
    {fmt_len, fmt_par_off, fmt_par_even, fmt_stop_sel} = c;
  endtask

  // write at a negedge; returns at the next negedge
  task automatic write_word(input logic [4:0] c, input logic [7:0] d);
    set_ctrl(c);
    wr_data = d;
    wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    check(hold_empty == 1'b0, "R6 hold_empty low after write", int'(hold_empty), 0);
  endtask

  // called at the negedge of the first start-bit clock
  task automatic check_frame(input logic [4:0] c, input logic [7:0] d, input int total,
                             input bit idle_after, input string tag);
    int bad = 0, busy = 0, first = -1;
    for (int k = 0; k < total; k++) begin
      if (txd !== exp_line(c, d, k)) begin
        bad++;
        if (first < 0) first = k;
      end
      if (tx_empty) busy++;
      @(negedge clk);
    end
    check(bad == 0, {tag, " R2 R3 R4 line bits (actual=bad clocks, first at)"}, bad, 0);
    if (bad != 0) $display("  first mismatch at clock %0d", first);
    check(busy == 0, {tag, " R8 tx_empty low while sending"}, busy, 0);
    if (idle_after) begin
      check(tx_empty == 1'b1, {tag, " R5 stop length ends exactly"}, int'(tx_empty), 1);
      check(txd == 1'b1, {tag, " R8 line high after character"}, int'(txd), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R1 txd in reset", int'(txd), 1);
    check(hold_empty == 1'b1, "R1 hold_empty in reset", int'(hold_empty), 1);
    check(tx_empty == 1'b1, "R1 tx_empty in reset", int'(tx_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd == 1'b1 && hold_empty && tx_empty, "R1 state after reset",
          int'({txd, hold_empty, tx_empty}), 7);

    // table walk: one character per vector
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] c;
      logic [7:0] d;
      c = VEC[v][22:18];
      d = VEC[v][17:10];
      write_word(c, d);
      @(negedge clk);
      check(hold_empty == 1'b1, "R6 hold_empty high after transfer", int'(hold_empty), 1);
      check_frame(c, d, frame_len(c, int'(VEC[v][9:6]), int'(VEC[v][5:0])), 1'b1,
                  $sformatf("vec%0d", v));
      repeat (3) @(negedge clk);
    end

    // R7: second word written while the first is on the line
    begin
      logic [4:0] ca, cb;
      ca = 5'b00001;
      cb = 5'b10100;
      write_word(ca, 8'h13);
      @(negedge clk);
      fork
        check_frame(ca, 8'h13, frame_len(ca, 5, 24), 1'b0, "b2b first");
        begin
          write_word(cb, 8'h5A);
          check(txd == 1'b0, "R7 first character still sending", int'(txd), 0);
        end
      join
      check(txd == 1'b0, "R7 next start bit with no gap", int'(txd), 0);
      check(hold_empty == 1'b1, "R6 buffer freed on transfer", int'(hold_empty), 1);
      check_frame(cb, 8'h5A, frame_len(cb, 7, 16), 1'b1, "b2b second R7");
      repeat (3) @(negedge clk);
    end

    // R9: format inputs change during a character
    begin
      logic [4:0] ca;
      ca = 5'b11011;
      write_word(ca, 8'h3C);
      @(negedge clk);
      fork
        check_frame(ca, 8'h3C, frame_len(ca, 8, 32), 1'b1, "R9 format change");
        begin
          repeat (20) @(negedge clk);
          set_ctrl(5'b00100);
        end
      join
      repeat (3) @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule